// File: doc/BRIEF.md
# Variable Page Size Translation Buffer

This block is a small, fully associative address translation buffer. It maps 32-bit effective addresses to 32-bit real addresses. Each entry carries its own page size, a power of four from 4 KB to 256 MB. An entry also carries a translation ID, an address-space bit, five storage attribute bits and six access permission bits.

Software prepares an entry in four staging registers: an index register, a tag register, an attribute register and a real-page register. A write strobe then copies the staged fields into the indexed entry. A read strobe does the opposite and loads the staging registers from the indexed entry, so every stored field can be read back at the staging outputs.

The lookup port is combinational. Every cycle it takes an effective address, a process ID, an address-space bit, an access kind and a supervisor flag. It returns a hit flag, the translated address, the attribute bits, a permission fault flag and a multi-hit flag. A bulk invalidate clears every entry that is not marked protected.

Top module: `vpage_xlat`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits, and all four staging outputs read zero.
- R2: Staging writes keep only their defined fields, and all other bits read zero. The bit positions are:
  - index register (stgSel=0): entry index at bits 19:16.
  - tag register (stgSel=1): valid at bit 31, protect at bit 30, ID at bits 23:16, space at bit 12, size code at bits 11:8.
  - attribute register (stgSel=2): effective page at bits 31:12, attributes at bits 4:0.
  - real-page register (stgSel=3): real page at bits 31:12, user bits at bits 9:6, permissions at bits 5:0.

  A read strobe loads the tag, attribute and real-page registers from the indexed entry, exactly as they were written.
- R3: An entry hits only when all of these hold:
  - its valid bit is set;
  - its space bit equals lkSpace;
  - its ID equals lkPid, or its ID is zero.
- R4: Size codes 1 to 9 give pages of 4 KB·4^(code−1). Codes 0 and 10 to 15 behave as 4 KB. Effective address bits inside the page do not take part in the compare.
- R5: On a hit, the translated address takes the real page bits above the page size. The bits inside the page come from the effective address.
- R6: On a hit, lkAttr shows the entry's attribute bits. On a miss, lkRa, lkAttr, lkFault and lkMulti are all zero.
- R7: On a hit, lkFault is set when the selected permission bit is clear. The bit is chosen by access kind and mode (lkAccess 0 = read, 1 = write, 2 or 3 = execute):
  - supervisor read uses bit 0; user read uses bit 1;
  - supervisor write uses bit 2; user write uses bit 3;
  - supervisor execute uses bit 4; user execute uses bit 5.
- R8: When several entries hit, the lowest-numbered entry supplies the result and lkMulti is set.
- R9: invAll clears the valid bit of every unprotected entry at the next clock edge. Protected entries keep translating.
- R10: An entry write takes effect at the clock edge that samples entryWrite. A lookup in the same cycle still sees the old contents.
- R11: The four user bits have no effect on any lookup output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stgWrEn | input | 1 | Write one staging register |
| stgSel | input | 2 | Staging register select (0 index, 1 tag, 2 attribute, 3 real page) |
| stgWrData | input | 32 | Staging write data |
| entryWrite | input | 1 | Copy staging registers into the indexed entry |
| entryRead | input | 1 | Load staging registers from the indexed entry |
| invAll | input | 1 | Bulk invalidate of unprotected entries |
| lkEa | input | 32 | Lookup effective address |
| lkPid | input | 8 | Current process ID |
| lkSpace | input | 1 | Current address-space bit |
| lkAccess | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| lkSuper | input | 1 | Supervisor mode |
| lkHit | output | 1 | Lookup hit |
| lkRa | output | 32 | Translated real address |
| lkAttr | output | 5 | Attribute bits of the hitting entry |
| lkFault | output | 1 | Permission fault |
| lkMulti | output | 1 | More than one entry hit |
| stgSelOut | output | 32 | Index staging register image |
| stgTagOut | output | 32 | Tag staging register image |
| stgAttrOut | output | 32 | Attribute staging register image |
| stgRealOut | output | 32 | Real-page staging register image |

## Verification
The assertions assume a synchronous reset held for at least one clock edge. They also assume that the index register is never written in the same cycle that it is observed as stable. The bench changes every input only on the falling clock edge and keeps strobes to a single cycle. It never raises entryWrite, entryRead and a staging write together, so each register update comes from one known source. Lookups are combinational, so the bench samples them a couple of nanoseconds after driving, well before the next rising edge.

// File: rtl/vpage_pkg.sv
package vpage_pkg;
  localparam int AddrW  = 32;
  localparam int OffW   = 12;
  localparam int PageW  = AddrW - OffW;
  localparam int TidW   = 8;
  localparam int AttrW  = 5;
  localparam int PermW  = 6;
  localparam int UserW  = 4;
  localparam int SizeW  = 4;
  localparam int MaxSizeCode = 9;

  typedef struct packed {
    logic             valid;
    logic             prot;
    logic [TidW-1:0]  tid;
    logic             space;
    logic [SizeW-1:0] size;
    logic [PageW-1:0] epn;
    logic [AttrW-1:0] attr;
    logic [PageW-1:0] rpn;
    logic [UserW-1:0] user;
    logic [PermW-1:0] perm;
  } entry_t;

  typedef struct packed {
    logic wr;
    logic rd;
    logic inv;
  } strobe_t;

  // Page-number bits that take part in the compare for a size code.
  function automatic logic [PageW-1:0] pageMask(input logic [SizeW-1:0] code);
    int lowBits;
    lowBits = (code >= 1 && code <= MaxSizeCode) ? 2 * (int'(code) - 1) : 0;
    return ~((PageW'(1) << lowBits) - PageW'(1));
  endfunction

  // Permission bit index for access kind and mode.
  function automatic logic [2:0] permIndex(input logic [1:0] acc, input logic sup);
    logic [2:0] base;
    case (acc)
      2'd0:    base = 3'd0;
      2'd1:    base = 3'd2;
      default: base = 3'd4;
    endcase
    return base + {2'b00, ~sup};
  endfunction
endpackage

// File: rtl/vpage_ctrl.sv
module vpage_ctrl
  import vpage_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IdxW = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stgWrEn,
  input  logic [1:0]       stgSel,
  input  logic [AddrW-1:0] stgWrData,
  input  logic             entryWrite,
  input  logic             entryRead,
  input  logic             invAll,
  input  entry_t           rdEntry,
  output strobe_t          strobes,
  output logic [IdxW-1:0]  selIdx,
  output entry_t           stgEntry,
  output logic [AddrW-1:0] stgSelOut,
  output logic [AddrW-1:0] stgTagOut,
  output logic [AddrW-1:0] stgAttrOut,
  output logic [AddrW-1:0] stgRealOut
);
  localparam int IdxLsb = 16;

  always_ff @(posedge clk) begin
    if (rst) begin
      selIdx   <= '0;
      stgEntry <= '0;
    end else begin
      if (stgWrEn && stgSel == 2'd0)
        selIdx <= stgWrData[IdxLsb +: IdxW];
      if (entryRead) begin
        stgEntry <= rdEntry;
      end else if (stgWrEn) begin
        case (stgSel)
          2'd1: begin
            stgEntry.valid <= stgWrData[31];
            stgEntry.prot  <= stgWrData[30];
            stgEntry.tid   <= stgWrData[16 +: TidW];
            stgEntry.space <= stgWrData[12];
            stgEntry.size  <= stgWrData[8 +: SizeW];
          end
          2'd2: begin
            stgEntry.epn  <= stgWrData[AddrW-1:OffW];
            stgEntry.attr <= stgWrData[AttrW-1:0];
          end
          2'd3: begin
            stgEntry.rpn  <= stgWrData[AddrW-1:OffW];
            stgEntry.user <= stgWrData[6 +: UserW];
            stgEntry.perm <= stgWrData[PermW-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobes.wr  = entryWrite;
    strobes.rd  = entryRead;
    strobes.inv = invAll;

    stgSelOut = '0;
    stgSelOut[IdxLsb +: IdxW] = selIdx;

    stgTagOut = '0;
    stgTagOut[31]          = stgEntry.valid;
    stgTagOut[30]          = stgEntry.prot;
    stgTagOut[16 +: TidW]  = stgEntry.tid;
    stgTagOut[12]          = stgEntry.space;
    stgTagOut[8 +: SizeW]  = stgEntry.size;

    stgAttrOut = '0;
    stgAttrOut[AddrW-1:OffW] = stgEntry.epn;
    stgAttrOut[AttrW-1:0]    = stgEntry.attr;

    stgRealOut = '0;
    stgRealOut[AddrW-1:OffW] = stgEntry.rpn;
    stgRealOut[6 +: UserW]   = stgEntry.user;
    stgRealOut[PermW-1:0]    = stgEntry.perm;
  end
endmodule

// File: rtl/vpage_datapath.sv
module vpage_datapath
  import vpage_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IdxW = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic [IdxW-1:0]  selIdx,
  input  entry_t           wrEntry,
  output entry_t           rdEntry,
  input  logic [AddrW-1:0] lkEa,
  input  logic [TidW-1:0]  lkPid,
  input  logic             lkSpace,
  input  logic [1:0]       lkAccess,
  input  logic             lkSuper,
  output logic             lkHit,
  output logic [AddrW-1:0] lkRa,
  output logic [AttrW-1:0] lkAttr,
  output logic             lkFault,
  output logic             lkMulti
);
  entry_t                 ents [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [IdxW-1:0]        winIdx;
  entry_t                 winEnt;
  logic [PageW-1:0]       winMask;
  logic [PageW-1:0]       eaPage;

  assign eaPage  = lkEa[AddrW-1:OffW];
  assign rdEntry = ents[selIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ents[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobes.wr && selIdx == IdxW'(i))
          ents[i] <= wrEntry;
        else if (strobes.inv && !ents[i].prot)
          ents[i].valid <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
    logic [PageW-1:0] cmpMask;
    logic             idOk;
    assign cmpMask   = pageMask(ents[g].size);
    assign idOk      = (ents[g].tid == '0) || (ents[g].tid == lkPid);
    assign hitVec[g] = ents[g].valid && (ents[g].space == lkSpace) && idOk &&
                       (((eaPage ^ ents[g].epn) & cmpMask) == '0);
  end

  always_comb begin
    winIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (hitVec[i]) winIdx = IdxW'(i);
  end

  assign winEnt  = ents[winIdx];
  assign winMask = pageMask(winEnt.size);
  assign lkHit   = |hitVec;
  assign lkMulti = (hitVec & (hitVec - 1'b1)) != '0;

  always_comb begin
    lkRa    = '0;
    lkAttr  = '0;
    lkFault = 1'b0;
    if (lkHit) begin
      lkRa    = {(winEnt.rpn & winMask) | (eaPage & ~winMask), lkEa[OffW-1:0]};
      lkAttr  = winEnt.attr;
      lkFault = !winEnt.perm[permIndex(lkAccess, lkSuper)];
    end
  end
endmodule

// File: rtl/vpage_xlat.sv
module vpage_xlat
  import vpage_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stgWrEn,
  input  logic [1:0]  stgSel,
  input  logic [31:0] stgWrData,
  input  logic        entryWrite,
  input  logic        entryRead,
  input  logic        invAll,
  input  logic [31:0] lkEa,
  input  logic [7:0]  lkPid,
  input  logic        lkSpace,
  input  logic [1:0]  lkAccess,
  input  logic        lkSuper,
  output logic        lkHit,
  output logic [31:0] lkRa,
  output logic [4:0]  lkAttr,
  output logic        lkFault,
  output logic        lkMulti,
  output logic [31:0] stgSelOut,
  output logic [31:0] stgTagOut,
  output logic [31:0] stgAttrOut,
  output logic [31:0] stgRealOut
);
  localparam int IdxW = $clog2(NUM_ENTRIES);

  strobe_t         strobes;
  logic [IdxW-1:0] selIdx;
  entry_t          stgEntry;
  entry_t          rdEntry;

  vpage_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) ctrl_i (
    .clk, .rst, .stgWrEn, .stgSel, .stgWrData, .entryWrite, .entryRead, .invAll,
    .rdEntry, .strobes, .selIdx, .stgEntry,
    .stgSelOut, .stgTagOut, .stgAttrOut, .stgRealOut
  );

  vpage_datapath #(.NUM_ENTRIES(NUM_ENTRIES)) dp_i (
    .clk, .rst, .strobes, .selIdx, .wrEntry(stgEntry), .rdEntry,
    .lkEa, .lkPid, .lkSpace, .lkAccess, .lkSuper,
    .lkHit, .lkRa, .lkAttr, .lkFault, .lkMulti
  );
endmodule

// File: rtl/vpage_xlat_chk.sv
module vpage_xlat_chk (
  input logic        clk,
  input logic        rst,
  input logic        stgWrEn,
  input logic [1:0]  stgSel,
  input logic [31:0] lkEa,
  input logic        lkHit,
  input logic [31:0] lkRa,
  input logic [4:0]  lkAttr,
  input logic        lkFault,
  input logic        lkMulti,
  input logic [31:0] stgSelOut
);
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lkHit);

  a_r6_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    !lkHit |-> (lkRa == 32'd0 && lkAttr == 5'd0 && !lkFault && !lkMulti));

  a_r5_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lkHit |-> lkRa[11:0] == lkEa[11:0]);

  a_r8_multi_needs_hit: assert property (@(posedge clk) disable iff (rst)
    lkMulti |-> lkHit);

  a_r2_index_holds: assert property (@(posedge clk) disable iff (rst)
    !($past(stgWrEn) && $past(stgSel) == 2'd0) |-> $stable(stgSelOut));
endmodule

bind vpage_xlat vpage_xlat_chk chk_i (
  .clk(clk), .rst(rst), .stgWrEn(stgWrEn), .stgSel(stgSel), .lkEa(lkEa),
  .lkHit(lkHit), .lkRa(lkRa), .lkAttr(lkAttr), .lkFault(lkFault),
  .lkMulti(lkMulti), .stgSelOut(stgSelOut)
);

// File: tb/vpage_xlat_tb_top.sv
module vpage_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stgWrEn = 0, entryWrite = 0, entryRead = 0, invAll = 0;
  logic [1:0]  stgSel = 0;
  logic [31:0] stgWrData = 0;
  logic [31:0] lkEa = 0;
  logic [7:0]  lkPid = 0;
  logic        lkSpace = 0, lkSuper = 0;
  logic [1:0]  lkAccess = 0;
  logic        lkHit, lkFault, lkMulti;
  logic [31:0] lkRa, stgSelOut, stgTagOut, stgAttrOut, stgRealOut;
  logic [4:0]  lkAttr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vpage_xlat dut_i (.*);

  // Reference contents of the buffer
  bit        mV [16];
  bit        mP [16];
  bit [7:0]  mTid [16];
  bit        mS [16];
  bit [3:0]  mSz [16];
  bit [19:0] mEpn [16];
  bit [4:0]  mAt [16];
  bit [19:0] mRpn [16];
  bit [3:0]  mU [16];
  bit [5:0]  mPm [16];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pageBytes(input bit [3:0] code);
    if (code >= 1 && code <= 9) return 32'd4096 << (2 * (code - 1));
    return 32'd4096;
  endfunction

  task automatic refLook(input logic [31:0] ea, input logic [7:0] pid, input bit sp,
                         input logic [1:0] acc, input bit sup,
                         output bit hit, output logic [31:0] ra, output logic [4:0] at,
                         output bit flt, output bit mul);
    int n = 0;
    int w = -1;
    int bitNo;
    logic [31:0] pb;
    for (int i = 0; i < 16; i++) begin
      pb = pageBytes(mSz[i]);
      if (mV[i] && mS[i] == sp && (mTid[i] == 0 || mTid[i] == pid) &&
          ((ea & ~(pb - 1)) == ({mEpn[i], 12'h000} & ~(pb - 1)))) begin
        n++;
        if (w < 0) w = i;
      end
    end
    hit = (n > 0); mul = (n > 1); ra = 0; at = 0; flt = 0;
    if (hit) begin
      pb = pageBytes(mSz[w]);
      ra = ({mRpn[w], 12'h000} & ~(pb - 1)) | (ea & (pb - 1));
      at = mAt[w];
      bitNo = (acc == 0) ? 0 : (acc == 1) ? 2 : 4;
      if (!sup) bitNo++;
      flt = !mPm[w][bitNo];
    end
  endtask

  task automatic stage(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    stgWrEn = 1; stgSel = sel; stgWrData = d;
    @(negedge clk);
    stgWrEn = 0;
  endtask

  task automatic loadStaging(input int idx, input bit v, input bit p, input logic [7:0] tid,
                             input bit sp, input logic [3:0] sz, input logic [19:0] epn,
                             input logic [4:0] at, input logic [19:0] rpn,
                             input logic [3:0] u, input logic [5:0] pm);
    stage(2'd0, 32'(idx) << 16);
    stage(2'd1, {v, p, 6'b0, tid, 3'b0, sp, sz, 8'b0});
    stage(2'd2, {epn, 7'b0, at});
    stage(2'd3, {rpn, 2'b0, u, pm});
  endtask

  task automatic commit(input int idx, input bit v, input bit p, input logic [7:0] tid,
                        input bit sp, input logic [3:0] sz, input logic [19:0] epn,
                        input logic [4:0] at, input logic [19:0] rpn,
                        input logic [3:0] u, input logic [5:0] pm);
    loadStaging(idx, v, p, tid, sp, sz, epn, at, rpn, u, pm);
    @(negedge clk);
    entryWrite = 1;
    @(negedge clk);
    entryWrite = 0;
    mV[idx] = v; mP[idx] = p; mTid[idx] = tid; mS[idx] = sp; mSz[idx] = sz;
    mEpn[idx] = epn; mAt[idx] = at; mRpn[idx] = rpn; mU[idx] = u; mPm[idx] = pm;
  endtask

  // Drives a lookup and compares every output with the reference
  task automatic look(input string req, input logic [31:0] ea, input logic [7:0] pid,
                      input bit sp, input logic [1:0] acc, input bit sup);
    bit eh, ef, em;
    logic [31:0] er;
    logic [4:0] ea5;
    @(negedge clk);
    lkEa = ea; lkPid = pid; lkSpace = sp; lkAccess = acc; lkSuper = sup;
    #2;
    refLook(ea, pid, sp, acc, sup, eh, er, ea5, ef, em);
    chk(req, "hit", 32'(lkHit), 32'(eh));
    chk(req, "ra", lkRa, er);
    chk(req, "attr", 32'(lkAttr), 32'(ea5));
    chk(req, "fault", 32'(lkFault), 32'(ef));
    chk(req, "multi", 32'(lkMulti), 32'(em));
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mV[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    #2;
    chk("R1", "tag", stgTagOut, 0);
    chk("R1", "sel", stgSelOut, 0);
    chk("R1", "attrreg", stgAttrOut, 0);
    chk("R1", "real", stgRealOut, 0);
    look("R1", 32'h0000_0000, 0, 0, 0, 1);
    look("R1", 32'hFFFF_F123, 8'h11, 1, 2, 0);

    // R2: staging masks
    stage(2'd0, 32'hFFFF_FFFF);
    chk("R2", "sel mask", stgSelOut, 32'h000F_0000);
    stage(2'd1, 32'hFFFF_FFFF);
    chk("R2", "tag mask", stgTagOut, 32'hC0FF_1F00);
    stage(2'd2, 32'hFFFF_FFFF);
    chk("R2", "attr mask", stgAttrOut, 32'hFFFF_F01F);
    stage(2'd3, 32'hFFFF_FFFF);
    chk("R2", "real mask", stgRealOut, 32'hFFFF_F3FF);

    // R4 R5 R6: sweep every size code, flip each page-number bit
    for (int code = 0; code < 16; code++) begin
      commit(0, 1, 0, 0, 0, 4'(code), 20'hABCDE, 5'(code) ^ 5'h15, 20'h12345, 0, 6'h3F);
      look("R4", 32'hABCD_E000, 8'h01, 0, 0, 1);
      look("R5", 32'hABCD_EABC, 8'h01, 0, 1, 0);
      for (int b = 0; b < 20; b++)
        look("R4", 32'hABCD_E5A5 ^ (32'd1 << (12 + b)), 8'h02, 0, 0, 1);
    end

    // R3: valid, space and ID rules
    commit(0, 0, 0, 0, 0, 4'd1, 20'hABCDE, 5'h1, 20'h12345, 0, 6'h3F);
    look("R3", 32'hABCD_E010, 0, 0, 0, 1);
    commit(1, 1, 0, 8'h5A, 1, 4'd1, 20'h00100, 5'h0A, 20'h00200, 0, 6'h3F);
    look("R3", 32'h0010_0444, 8'h5A, 1, 0, 1);
    look("R3", 32'h0010_0444, 8'h5B, 1, 0, 1);
    look("R3", 32'h0010_0444, 8'h5A, 0, 0, 1);
    commit(2, 1, 0, 8'h00, 0, 4'd2, 20'h30000, 5'h11, 20'h40000, 0, 6'h3F);
    look("R3", 32'h3000_3ABC, 8'hC3, 0, 0, 1);
    look("R3", 32'h3000_3ABC, 8'h00, 1, 0, 1);

    // R7: permission sweep
    for (int pm = 0; pm < 64; pm++) begin
      commit(1, 1, 0, 8'h5A, 1, 4'd1, 20'h00100, 5'h0A, 20'h00200, 0, 6'(pm));
      for (int acc = 0; acc < 4; acc++)
        for (int sup = 0; sup < 2; sup++)
          look("R7", 32'h0010_0FF8, 8'h5A, 1, 2'(acc), sup[0]);
    end

    // R8: overlapping entries
    commit(9, 1, 0, 0, 0, 4'd1, 20'h77777, 5'h09, 20'h99999, 0, 6'h3F);
    commit(4, 1, 0, 0, 0, 4'd3, 20'h77770, 5'h04, 20'h44440, 0, 6'h15);
    look("R8", 32'h7777_7123, 8'h33, 0, 1, 0);
    chk("R8", "winner ra", lkRa, 32'h4444_7123);
    chk("R8", "multi flag", 32'(lkMulti), 1);

    // R11: user bits change nothing
    commit(4, 1, 0, 0, 0, 4'd3, 20'h77770, 5'h04, 20'h44440, 4'hF, 6'h15);
    look("R11", 32'h7777_7123, 8'h33, 0, 1, 0);
    look("R11", 32'h7777_0FFF, 8'h33, 0, 0, 1);

    // R2: read back through staging after clobbering it
    commit(5, 1, 1, 8'hA7, 1, 4'd6, 20'hDEAD0, 5'h1B, 20'hBEEF0, 4'h9, 6'h2D);
    loadStaging(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    stage(2'd0, 32'(5) << 16);
    @(negedge clk);
    entryRead = 1;
    @(negedge clk);
    entryRead = 0;
    #2;
    chk("R2", "readback tag", stgTagOut, {1'b1, 1'b1, 6'b0, 8'hA7, 3'b0, 1'b1, 4'd6, 8'b0});
    chk("R2", "readback attr", stgAttrOut, {20'hDEAD0, 7'b0, 5'h1B});
    chk("R2", "readback real", stgRealOut, {20'hBEEF0, 2'b0, 4'h9, 6'h2D});
    chk("R2", "readback sel", stgSelOut, 32'h0005_0000);

    // R10: write visible only after the sampling edge
    loadStaging(7, 1, 0, 0, 0, 4'd1, 20'h55555, 5'h07, 20'h66666, 0, 6'h3F);
    @(negedge clk);
    entryWrite = 1; lkEa = 32'h5555_5321; lkPid = 0; lkSpace = 0; lkAccess = 0; lkSuper = 1;
    #2;
    chk("R10", "same cycle miss", 32'(lkHit), 0);
    @(negedge clk);
    entryWrite = 0;
    #2;
    chk("R10", "next cycle hit", 32'(lkHit), 1);
    chk("R10", "next cycle ra", lkRa, 32'h6666_6321);
    mV[7] = 1; mP[7] = 0; mTid[7] = 0; mS[7] = 0; mSz[7] = 1;
    mEpn[7] = 20'h55555; mAt[7] = 5'h07; mRpn[7] = 20'h66666; mU[7] = 0; mPm[7] = 6'h3F;

    // R9: bulk invalidate keeps protected entry 5
    @(negedge clk);
    invAll = 1;
    @(negedge clk);
    invAll = 0;
    for (int i = 0; i < 16; i++) if (!mP[i]) mV[i] = 0;
    look("R9", 32'hDEAD_4567, 8'hA7, 1, 0, 1);
    look("R9", 32'h5555_5321, 0, 0, 0, 1);
    look("R9", 32'h7777_7123, 0, 0, 0, 1);
    look("R9", 32'h3000_3ABC, 0, 0, 0, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule